// File: doc/BRIEF.md
# Converter Register Target on a Two-Wire Serial Bus

This block is the bus-facing front end of a small data-converter peripheral. It watches a two-wire serial bus (a clock line and an open-drain data line), both sampled with the fast system clock. It answers to one 7-bit target address. The upper four bits of that address are fixed at `1001`, and the lower three are taken from strap pins. The block never drives the data line high: it only asserts an open-drain pull-down enable.

In a write transfer, the first byte after the address is kept as the converter control setting. Every byte after that is a new code for the digital-to-analog path, and that code is held until the next byte replaces it. In a read transfer, each acknowledge that lets the transfer continue fires a one-cycle conversion-start strobe. The byte then sent out is the result of the conversion started one step earlier. Before any conversion has been started since reset, that byte is a fixed idle code of 0x80.

Top module: `conv_i2c_target`

## Requirements
- R1: The block accepts an address byte (sent most significant bit first) whose bits 7..4 are `1001` and whose bits 3..1 equal `strap_i[2:0]`. Bit 0 selects the direction: 0 is write, 1 is read.
- R2: In a write transfer, the first data byte after the address is loaded into `ctrl_o`.
- R3: In a write transfer, each data byte after the first is loaded into `dac_o`. `dac_o` keeps that value until another such byte arrives, including across STOP.
- R4: The block pulls the data line low (`sda_oe`=1) during the acknowledge clock after a matching address byte and after every byte it receives in a write.
- R5: In a read transfer, each byte sent is the value of `result_i` captured when that byte's transmission starts. Before the first conversion strobe since reset, the byte sent is 0x80. Reads never change `ctrl_o` or `dac_o`.
- R6: `conv_start_o` pulses high for exactly one cycle after the falling clock edge that ends the address acknowledge of a read, and after the falling clock edge that ends each acknowledge the master gives to a read byte.
- R7: When the master does not acknowledge a read byte, the block releases the data line (`sda_oe`=0), sends nothing more and fires no strobe.
- R8: A write transfer ends on STOP or on a repeated START. After a repeated START with a matching write address, the first data byte goes to `ctrl_o` again.
- R9: Synchronous reset clears `ctrl_o` and `dac_o` to 0, and leaves `sda_oe` and `conv_start_o` low.
- R10: After an address byte that does not match, the block never drives the data line and changes no output until the next START.
- R11: `sda_oe` changes only while the clock line is low, except that START and STOP release it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | Open-drain enable: 1 pulls the data line low |
| strap_i | input | 3 | Low three address bits, taken from strap pins |
| result_i | input | 8 | Latest conversion result from the converter |
| ctrl_o | output | 8 | Converter control setting (first write byte) |
| dac_o | output | 8 | Digital-to-analog code (later write bytes) |
| conv_start_o | output | 1 | One-cycle strobe that starts the next conversion |

## Verification
The hardest case to reach from the ports is the read pipeline. Here the byte on the wire is the conversion result captured at one strobe, while `result_i` has already moved on to the next value. The bench changes `result_i` between acknowledges of the same read and again between separate read transfers, so a design that sends the current value instead of the captured one gives a wrong byte. The fixed 0x80 byte only appears before any strobe since reset, so the first read is placed after reset and after several writes that must not count as conversions. A repeated START in the middle of a write, together with an address that differs only in a strap bit, checks that the byte-role tracking restarts and that address matching follows the straps.

// File: rtl/conv_i2c_pkg.sv
package conv_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] sync_o,
  output logic [LINES-1:0] prev_o
);
  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_line
      logic [STAGES:0] pipe_q;
      always_ff @(posedge clk) begin
        if (rst) pipe_q <= '1;
        else     pipe_q <= {pipe_q[STAGES-1:0], raw_i[g]};
      end
      assign sync_o[g] = pipe_q[STAGES-1];
      assign prev_o[g] = pipe_q[STAGES];
    end
  endgenerate
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic scl_s,
  input  logic scl_q,
  input  logic sda_s,
  input  logic sda_q,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  always_comb begin
    start_o    = scl_s & scl_q & sda_q & ~sda_s;
    stop_o     = scl_s & scl_q & ~sda_q & sda_s;
    scl_rise_o = scl_s & ~scl_q;
    scl_fall_o = ~scl_s & scl_q;
  end
endmodule

// File: rtl/conv_i2c_target.sv
module conv_i2c_target
  import conv_i2c_pkg::*;
#(
  parameter int                          STRAP_W     = 3,
  parameter logic [ADDR_W-STRAP_W-1:0]   ADDR_FIXED  = 4'b1001,
  parameter int                          SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0]           RESULT_INIT = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [BYTE_W-1:0] result_i,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic [BYTE_W-1:0] dac_o,
  output logic              conv_start_o
);
  logic [1:0] line_s, line_q;
  logic scl_s, scl_q, sda_s, sda_q;
  logic ev_start, ev_stop, ev_rise, ev_fall;

  i2c_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .raw_i({scl_i, sda_i}),
    .sync_o(line_s), .prev_o(line_q)
  );

  assign scl_s = line_s[1];
  assign sda_s = line_s[0];
  assign scl_q = line_q[1];
  assign sda_q = line_q[0];

  i2c_bus_events u_evt (
    .scl_s(scl_s), .scl_q(scl_q), .sda_s(sda_s), .sda_q(sda_q),
    .start_o(ev_start), .stop_o(ev_stop),
    .scl_rise_o(ev_rise), .scl_fall_o(ev_fall)
  );

  tgt_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] ctrl_q, dac_q;
  logic              first_q, mack_q, have_res_q, oe_q, strobe_q;

  logic              addr_hit;
  logic [BYTE_W-1:0] tx_next;
  logic              byte_done;

  assign addr_hit  = (sh_q[BYTE_W-1:1] == {ADDR_FIXED, strap_i});
  assign tx_next   = have_res_q ? result_i : RESULT_INIT;
  assign byte_done = (cnt_q == CNT_W'(BYTE_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      ctrl_q     <= '0;
      dac_q      <= '0;
      first_q    <= 1'b1;
      mack_q     <= 1'b0;
      have_res_q <= 1'b0;
      oe_q       <= 1'b0;
      strobe_q   <= 1'b0;
    end else begin
      strobe_q <= 1'b0;
      if (ev_start) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else if (ev_stop) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else begin
        case (state_q)
          ST_IDLE: ;
          ST_ADDR: begin
            if (ev_rise) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_s};
              cnt_q <= cnt_q + 1'b1;
            end else if (ev_fall && byte_done) begin
              if (addr_hit) begin
                state_q <= ST_ADDR_ACK;
                oe_q    <= 1'b1;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (ev_fall) begin
              cnt_q <= '0;
              if (sh_q[0]) begin
                state_q    <= ST_RD;
                sh_q       <= tx_next;
                oe_q       <= ~tx_next[BYTE_W-1];
                strobe_q   <= 1'b1;
                have_res_q <= 1'b1;
              end else begin
                state_q <= ST_WR;
                oe_q    <= 1'b0;
                first_q <= 1'b1;
              end
            end
          end
          ST_WR: begin
            if (ev_rise) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_s};
              cnt_q <= cnt_q + 1'b1;
            end else if (ev_fall && byte_done) begin
              if (first_q) begin
                ctrl_q  <= sh_q;
                first_q <= 1'b0;
              end else begin
                dac_q <= sh_q;
              end
              oe_q    <= 1'b1;
              state_q <= ST_WR_ACK;
            end
          end
          ST_WR_ACK: begin
            if (ev_fall) begin
              oe_q    <= 1'b0;
              cnt_q   <= '0;
              state_q <= ST_WR;
            end
          end
          ST_RD: begin
            if (ev_rise) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (ev_fall) begin
              if (byte_done) begin
                oe_q    <= 1'b0;
                state_q <= ST_RD_ACK;
              end else begin
                sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
                oe_q <= ~sh_q[BYTE_W-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (ev_rise) begin
              mack_q <= ~sda_s;
            end else if (ev_fall) begin
              cnt_q <= '0;
              if (mack_q) begin
                state_q    <= ST_RD;
                sh_q       <= tx_next;
                oe_q       <= ~tx_next[BYTE_W-1];
                strobe_q   <= 1'b1;
                have_res_q <= 1'b1;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_oe       = oe_q;
  assign ctrl_o       = ctrl_q;
  assign dac_o        = dac_q;
  assign conv_start_o = strobe_q;
endmodule

// File: rtl/conv_i2c_target_chk.sv
module conv_i2c_target_chk
  import conv_i2c_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              scl_s,
  input logic              sda_oe,
  input logic              conv_start,
  input logic [BYTE_W-1:0] ctrl,
  input logic [BYTE_W-1:0] dac,
  input tgt_state_e        state
);
  AST_OE_CHANGES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s)); // R11

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start); // R6

  AST_STROBE_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> !$past(scl_s)); // R6

  AST_READ_KEEPS_REGS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RD || state == ST_RD_ACK) |=> ($stable(ctrl) && $stable(dac))); // R5

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ctrl == '0 && dac == '0 && !sda_oe && !conv_start)); // R9

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe); // R10
endmodule

bind conv_i2c_target conv_i2c_target_chk u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .sda_oe(sda_oe),
  .conv_start(conv_start_o), .ctrl(ctrl_o), .dac(dac_o), .state(state_q)
);

// File: tb/conv_i2c_target_tb.sv
module conv_i2c_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] strap = 3'b010;
  logic [7:0] result = 8'h00;
  logic       sda_oe, conv_start;
  logic [7:0] ctrl, dac;
  wire        sda_line = sda_m & ~sda_oe;

  int tests = 0;
  int fails = 0;
  int strobes = 0;
  int hi_changes = 0;
  int hi_cnt = 0;
  logic oe_prev = 1'b0;
  bit done = 0;

  logic [7:0] exp_q[$];
  logic [7:0] rx_byte;
  event rx_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_i2c_target u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_i(strap), .result_i(result), .ctrl_o(ctrl), .dac_o(dac),
    .conv_start_o(conv_start)
  );

  always @(posedge clk) begin
    if (!rst && conv_start) strobes <= strobes + 1;
    hi_cnt  <= scl_m ? hi_cnt + 1 : 0;
    oe_prev <= sda_oe;
    if (!rst && scl_m && hi_cnt > 4 && sda_oe != oe_prev) hi_changes <= hi_changes + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: pops the expected read byte and compares it
  initial forever begin
    @(rx_ev);
    tests++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL R5: actual 0x%0h expected none queued", rx_byte);
    end else begin
      logic [7:0] e;
      e = exp_q.pop_front();
      if (rx_byte != e) begin
        fails++;
        $display("FAIL R5: read byte actual 0x%0h expected 0x%0h", rx_byte, e);
      end
    end
  end

  task automatic wait_q();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q(); scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q(); scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(); scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
  endtask

  task automatic send(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_q(); scl_m = 1'b1; wait_q(); wait_q();
      scl_m = 1'b0; wait_q();
    end
    sda_m = 1'b1; wait_q(); scl_m = 1'b1; wait_q();
    acked = ~sda_line; wait_q(); scl_m = 1'b0; wait_q();
  endtask

  task automatic recv(input logic give_ack, input logic [7:0] expect_b);
    logic [7:0] b;
    exp_q.push_back(expect_b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_q(); scl_m = 1'b1; wait_q(); b[i] = sda_line; wait_q();
      scl_m = 1'b0;
    end
    wait_q();
    sda_m = ~give_ack; wait_q(); scl_m = 1'b1; wait_q(); wait_q();
    scl_m = 1'b0; wait_q(); sda_m = 1'b1;
    rx_byte = b;
    -> rx_ev;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic ack;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 ctrl", ctrl, 8'h00);
    chk("R9 dac", dac, 8'h00);
    chk("R9 sda_oe", sda_oe, 0);
    chk("R9 strobe", conv_start, 0);

    // write: control then two DAC codes
    bus_start();
    send(8'h94, ack); chk("R1 R4 address ack", ack, 1);
    send(8'h45, ack); chk("R4 ctrl ack", ack, 1);
    chk("R2 ctrl load", ctrl, 8'h45);
    send(8'h12, ack); chk("R3 dac first", dac, 8'h12);
    chk("R2 ctrl held", ctrl, 8'h45);
    send(8'hFE, ack); chk("R3 dac second", dac, 8'hFE);
    bus_stop();
    repeat (50) @(negedge clk);
    chk("R3 dac held after stop", dac, 8'hFE);
    chk("R6 no strobe on write", strobes, 0);

    // address with a different strap value is ignored
    bus_start();
    send(8'h96, ack); chk("R10 no address ack", ack, 0);
    send(8'h5A, ack); chk("R10 no data ack", ack, 0);
    chk("R10 ctrl unchanged", ctrl, 8'h45);
    chk("R10 dac unchanged", dac, 8'hFE);
    bus_stop();

    // repeated START restarts the byte roles
    bus_start();
    send(8'h94, ack); send(8'h07, ack);
    chk("R2 ctrl load again", ctrl, 8'h07);
    bus_start();
    send(8'h94, ack); chk("R8 ack after restart", ack, 1);
    send(8'h33, ack); chk("R8 first byte is control", ctrl, 8'h33);
    chk("R8 dac untouched", dac, 8'hFE);
    send(8'h66, ack); chk("R3 dac after restart", dac, 8'h66);
    bus_stop();

    // reads: idle code, then captured results
    result = 8'h3C;
    bus_start();
    send(8'h95, ack); chk("R4 read address ack", ack, 1);
    chk("R6 strobe on address ack", strobes, 1);
    recv(1'b1, 8'h80);
    chk("R6 strobe on master ack", strobes, 2);
    result = 8'h71;
    recv(1'b0, 8'h3C);
    chk("R7 no strobe on nack", strobes, 2);
    chk("R7 released after nack", sda_oe, 0);
    bus_stop();

    strap = 3'b101;
    bus_start();
    send(8'h9B, ack); chk("R1 strap follows pins", ack, 1);
    recv(1'b0, 8'h71);
    chk("R6 strobe count", strobes, 3);
    bus_stop();
    chk("R5 ctrl kept by reads", ctrl, 8'h33);
    chk("R5 dac kept by reads", dac, 8'h66);
    repeat (20) @(negedge clk);
    chk("R11 no drive change while clock high", hi_changes, 0);
    chk("R5 all reads compared", exp_q.size(), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule